// File: doc/BRIEF.md
# Physical Register Wakeup Scoreboard

This block tracks which physical registers of an out-of-order core hold a produced value, and which waiting queue entries still need each register. Rename hands it one instruction per cycle: a queue entry number, up to two renamed source registers and one renamed destination. The block clears the destination's ready bit. Each source that is still outstanding is recorded as a waiter on its register.

A completion names one destination register per cycle. It sets that register's ready bit and releases every waiting operand in one cycle. Each entry then raises a registered "all operands ready" flag that a separate issue selector can use. A squash mask drops entries and erases their waiting records.

Two details keep the tracking exact. A source is rechecked against the scoreboard and against the completion of the same cycle, so a value produced while the instruction was in flight is never missed. Register indices past the physical range are not tracked at all.

Top module: `preg_wakeup_sb`

## Requirements
- R1: While reset is high, and in the first cycle after it, every bit of `preg_ready` and `entry_ready` is 0 and `dup_err` is 0.
- R2: An insert with `ins_dst_vld`=1 and an in-range `ins_dst` clears that register's `preg_ready` bit in the next cycle. This holds even when the same register completes in the same cycle.
- R3: A completion with an in-range `cmp_dst` sets that register's `preg_ready` bit in the next cycle. In that same cycle it releases every operand of every entry waiting on it, so all of those entries whose operands are now satisfied show `entry_ready`=1.
- R4: A source with `ins_src_vld`=0, or with its `ins_src_rdy` bit set, needs nothing. An entry with no other pending source shows `entry_ready`=1 one cycle after the insert.
- R5: A source whose `preg_ready` bit is already 1 at insert is satisfied immediately and is not enlisted.
- R6: A source equal to the in-range `cmp_dst` completing in the insert cycle is satisfied immediately.
- R7: An outstanding source keeps `entry_ready` at 0 until its register completes. With two outstanding sources, both registers must complete.
- R8: When both sources name the same outstanding register, one completion satisfies both.
- R9: `sq_mask` bit e drops entry e, so `entry_ready[e]` is 0 in the next cycle unless entry e is inserted in that same cycle. The entry is also removed from every waiter list.
- R10: Register indices at or above `INT_REGS+FP_REGS` are ignored. Such a completion changes no `preg_ready` bit, such a destination clears nothing, and such a source counts as satisfied.
- R11: An insert whose in-range destination still has waiters, not counting entries squashed or overwritten in that cycle, raises `dup_err` for exactly the next cycle. If that register also completes in the insert cycle, `dup_err` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert an instruction this cycle |
| ins_entry | input | $clog2(ENTRIES) | Queue entry being filled |
| ins_src_vld | input | 2 | Per-operand: operand exists |
| ins_src_rdy | input | 2 | Per-operand: rename already found it ready |
| ins_src0 | input | IW | Renamed register of operand 0 |
| ins_src1 | input | IW | Renamed register of operand 1 |
| ins_dst_vld | input | 1 | Instruction writes a register |
| ins_dst | input | IW | Renamed destination register |
| cmp_valid | input | 1 | A completion is reported |
| cmp_dst | input | IW | Register produced by the completion |
| sq_mask | input | ENTRIES | Entries squashed this cycle |
| entry_ready | output | ENTRIES | Registered: entry valid with all operands satisfied |
| preg_ready | output | INT_REGS+FP_REGS | Registered per-register ready bits |
| dup_err | output | 1 | Registered: destination reallocated while it still had waiters |

## Verification
The bench builds the block with four integer and four floating registers, four entries and 4-bit indices. With these values, indices 8 to 15 lie outside the physical range yet fit the ports, so out-of-range completions, sources and destinations can be driven. Four entries are few enough that every entry gets reused after a squash. That reuse makes it possible to see, through `dup_err`, that squashed entries left no stale waiter behind. The eight registers also allow same-cycle insert and completion collisions to be placed on specific registers.

// File: rtl/pws_pkg.sv
package pws_pkg;
  // operand slots carried by each queue entry
  localparam int NSRC = 2;
endpackage

// File: rtl/pws_ready_vec.sv
module pws_ready_vec #(
  parameter int NPREG = 32,
  parameter int IW    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_vld,
  input  logic [IW-1:0]    set_idx,
  input  logic             clr_vld,
  input  logic [IW-1:0]    clr_idx,
  output logic [NPREG-1:0] rdy
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdy <= '0;
    end else begin
      for (int r = 0; r < NPREG; r++) begin
        // reallocation of a register wins over a late completion
        if (clr_vld && int'(clr_idx) == r)      rdy[r] <= 1'b0;
        else if (set_vld && int'(set_idx) == r) rdy[r] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pws_wait_matrix.sv
module pws_wait_matrix #(
  parameter int NPREG   = 32,
  parameter int ENTRIES = 16,
  parameter int IW      = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wake_vld,
  input  logic [IW-1:0]      wake_idx,
  input  logic               set_vld,
  input  logic [IW-1:0]      set_row,
  input  logic [ENTRIES-1:0] set_col,
  input  logic [ENTRIES-1:0] clr_cols,
  input  logic [IW-1:0]      q_idx,
  output logic [ENTRIES-1:0] wake_row,
  output logic [ENTRIES-1:0] q_row
);
  logic [ENTRIES-1:0] wm [NPREG];

  always_comb begin
    wake_row = '0;
    q_row    = '0;
    for (int r = 0; r < NPREG; r++) begin
      if (wake_vld && int'(wake_idx) == r) wake_row = wm[r];
      if (int'(q_idx) == r)                q_row    = wm[r];
    end
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < NPREG; r++) begin
      if (rst)
        wm[r] <= '0;
      else if (wake_vld && int'(wake_idx) == r)
        wm[r] <= '0;
      else
        wm[r] <= (wm[r] & ~clr_cols) |
                 ((set_vld && int'(set_row) == r) ? set_col : '0);
    end
  end
endmodule

// File: rtl/pws_entry_slots.sv
module pws_entry_slots
  import pws_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [ENTRIES-1:0]             ins_sel,
  input  logic [NSRC-1:0]                ins_op_vld,
  input  logic [NSRC-1:0]                ins_op_rdy,
  input  logic [NSRC-1:0][ENTRIES-1:0]   wake_hit,
  input  logic [ENTRIES-1:0]             sq_mask,
  output logic [ENTRIES-1:0]             entry_ready
);
  logic [ENTRIES-1:0]           vld_q, vld_n;
  logic [ENTRIES-1:0][NSRC-1:0] opv_q, opv_n, opr_q, opr_n;
  logic [ENTRIES-1:0]           rdy_n;

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      vld_n[e] = vld_q[e];
      opv_n[e] = opv_q[e];
      opr_n[e] = opr_q[e];
      if (ins_sel[e]) begin
        vld_n[e] = 1'b1;
        opv_n[e] = ins_op_vld;
        opr_n[e] = ins_op_rdy;
      end else if (sq_mask[e]) begin
        vld_n[e] = 1'b0;
      end else begin
        for (int k = 0; k < NSRC; k++)
          if (wake_hit[k][e]) opr_n[e][k] = 1'b1;
      end
      rdy_n[e] = vld_n[e] && ((~opv_n[e] | opr_n[e]) == '1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q       <= '0;
      opv_q       <= '0;
      opr_q       <= '0;
      entry_ready <= '0;
    end else begin
      vld_q       <= vld_n;
      opv_q       <= opv_n;
      opr_q       <= opr_n;
      entry_ready <= rdy_n;
    end
  end
endmodule

// File: rtl/preg_wakeup_sb.sv
module preg_wakeup_sb
  import pws_pkg::*;
#(
  parameter int INT_REGS = 16,
  parameter int FP_REGS  = 16,
  parameter int ENTRIES  = 16,
  parameter int IW       = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ins_valid,
  input  logic [$clog2(ENTRIES)-1:0]  ins_entry,
  input  logic [1:0]                  ins_src_vld,
  input  logic [1:0]                  ins_src_rdy,
  input  logic [IW-1:0]               ins_src0,
  input  logic [IW-1:0]               ins_src1,
  input  logic                        ins_dst_vld,
  input  logic [IW-1:0]               ins_dst,
  input  logic                        cmp_valid,
  input  logic [IW-1:0]               cmp_dst,
  input  logic [ENTRIES-1:0]          sq_mask,
  output logic [ENTRIES-1:0]          entry_ready,
  output logic [INT_REGS+FP_REGS-1:0] preg_ready,
  output logic                        dup_err
);
  localparam int NPREG = INT_REGS + FP_REGS;
  localparam int EW    = $clog2(ENTRIES);

  logic [NSRC-1:0][IW-1:0]      src;
  logic [NSRC-1:0]              byp, enlist;
  logic [NSRC-1:0][ENTRIES-1:0] wake_row, q_row;
  logic [ENTRIES-1:0]           ins_sel, waiters;
  logic                         cmp_hit, dst_trk, dup_n;

  assign src[0] = ins_src0;
  assign src[1] = ins_src1;

  assign cmp_hit = cmp_valid && (int'(cmp_dst) < NPREG);
  assign dst_trk = ins_valid && ins_dst_vld && (int'(ins_dst) < NPREG);

  always_comb begin
    for (int e = 0; e < ENTRIES; e++)
      ins_sel[e] = ins_valid && (ins_entry == EW'(e));
  end

  // source recheck: scoreboard bit or a completion landing this cycle
  always_comb begin
    for (int k = 0; k < NSRC; k++) begin
      byp[k] = 1'b0;
      for (int r = 0; r < NPREG; r++)
        if (int'(src[k]) == r && preg_ready[r]) byp[k] = 1'b1;
      if (cmp_hit && cmp_dst == src[k]) byp[k] = 1'b1;
      enlist[k] = ins_valid && ins_src_vld[k] && !ins_src_rdy[k] &&
                  (int'(src[k]) < NPREG) && !byp[k];
    end
  end

  pws_ready_vec #(.NPREG(NPREG), .IW(IW)) u_rdy (
    .clk     (clk),
    .rst     (rst),
    .set_vld (cmp_hit),
    .set_idx (cmp_dst),
    .clr_vld (dst_trk),
    .clr_idx (ins_dst),
    .rdy     (preg_ready)
  );

  for (genvar k = 0; k < NSRC; k++) begin : g_op
    pws_wait_matrix #(.NPREG(NPREG), .ENTRIES(ENTRIES), .IW(IW)) u_wm (
      .clk      (clk),
      .rst      (rst),
      .wake_vld (cmp_hit),
      .wake_idx (cmp_dst),
      .set_vld  (enlist[k]),
      .set_row  (src[k]),
      .set_col  (ins_sel),
      .clr_cols (sq_mask | ins_sel),
      .q_idx    (ins_dst),
      .wake_row (wake_row[k]),
      .q_row    (q_row[k])
    );
  end

  pws_entry_slots #(.ENTRIES(ENTRIES)) u_slots (
    .clk         (clk),
    .rst         (rst),
    .ins_sel     (ins_sel),
    .ins_op_vld  (ins_src_vld),
    .ins_op_rdy  (~enlist),
    .wake_hit    (wake_row),
    .sq_mask     (sq_mask),
    .entry_ready (entry_ready)
  );

  assign waiters = (q_row[0] | q_row[1]) & ~sq_mask & ~ins_sel;
  assign dup_n   = dst_trk && (waiters != '0) &&
                   !(cmp_hit && cmp_dst == ins_dst);

  always_ff @(posedge clk) begin
    if (rst) dup_err <= 1'b0;
    else     dup_err <= dup_n;
  end
endmodule

// File: rtl/pws_sb_chk.sv
module pws_sb_chk #(
  parameter int INT_REGS = 16,
  parameter int FP_REGS  = 16,
  parameter int ENTRIES  = 16,
  parameter int IW       = 6
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        ins_valid,
  input logic [$clog2(ENTRIES)-1:0]  ins_entry,
  input logic                        ins_dst_vld,
  input logic [IW-1:0]               ins_dst,
  input logic                        cmp_valid,
  input logic [IW-1:0]               cmp_dst,
  input logic [ENTRIES-1:0]          sq_mask,
  input logic [ENTRIES-1:0]          entry_ready,
  input logic [INT_REGS+FP_REGS-1:0] preg_ready,
  input logic                        dup_err
);
  localparam int NPREG = INT_REGS + FP_REGS;
  localparam int EW    = $clog2(ENTRIES);

  logic [NPREG-1:0] dst_oh, cmp_oh;
  logic             dst_in, cmp_in;

  always_comb begin
    for (int r = 0; r < NPREG; r++) begin
      dst_oh[r] = (int'(ins_dst) == r);
      cmp_oh[r] = (int'(cmp_dst) == r);
    end
  end
  assign dst_in = ins_valid && ins_dst_vld && (int'(ins_dst) < NPREG);
  assign cmp_in = cmp_valid && (int'(cmp_dst) < NPREG);

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (preg_ready == '0 && entry_ready == '0 && !dup_err));

  // R2
  a_r2_dst_cleared: assert property (@(posedge clk) disable iff (rst)
    dst_in |=> ((preg_ready & $past(dst_oh)) == '0));

  // R3
  a_r3_cmp_sets: assert property (@(posedge clk) disable iff (rst)
    (cmp_in && !(dst_in && ins_dst == cmp_dst)) |=> ((preg_ready & $past(cmp_oh)) != '0));

  // R10
  a_r10_oor_cmp_ignored: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && int'(cmp_dst) >= NPREG && !ins_valid) |=> (preg_ready == $past(preg_ready)));

  // R9
  for (genvar e = 0; e < ENTRIES; e++) begin : g_sq
    a_r9_squash_drops: assert property (@(posedge clk) disable iff (rst)
      (sq_mask[e] && !(ins_valid && ins_entry == EW'(e))) |=> !entry_ready[e]);
  end
endmodule

bind preg_wakeup_sb pws_sb_chk #(
  .INT_REGS(INT_REGS), .FP_REGS(FP_REGS), .ENTRIES(ENTRIES), .IW(IW)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ins_valid   (ins_valid),
  .ins_entry   (ins_entry),
  .ins_dst_vld (ins_dst_vld),
  .ins_dst     (ins_dst),
  .cmp_valid   (cmp_valid),
  .cmp_dst     (cmp_dst),
  .sq_mask     (sq_mask),
  .entry_ready (entry_ready),
  .preg_ready  (preg_ready),
  .dup_err     (dup_err)
);

// File: tb/preg_wakeup_sb_tb.sv
module preg_wakeup_sb_tb;
  localparam int IR = 4, FR = 4, NE = 4, IW = 4;
  localparam int NP = IR + FR;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ins_valid = 0;
  logic [1:0]    ins_entry = 0;
  logic [1:0]    ins_src_vld = 0, ins_src_rdy = 0;
  logic [IW-1:0] ins_src0 = 0, ins_src1 = 0, ins_dst = 0, cmp_dst = 0;
  logic          ins_dst_vld = 0, cmp_valid = 0;
  logic [NE-1:0] sq_mask = 0;
  logic [NE-1:0] entry_ready;
  logic [NP-1:0] preg_ready;
  logic          dup_err;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  string         q_req[$];
  logic [NE-1:0] q_er[$];
  logic [NP-1:0] q_pr[$];
  logic          q_de[$];

  always #10 clk = ~clk;

  preg_wakeup_sb #(.INT_REGS(IR), .FP_REGS(FR), .ENTRIES(NE), .IW(IW)) u_dut (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_entry(ins_entry),
    .ins_src_vld(ins_src_vld), .ins_src_rdy(ins_src_rdy),
    .ins_src0(ins_src0), .ins_src1(ins_src1),
    .ins_dst_vld(ins_dst_vld), .ins_dst(ins_dst),
    .cmp_valid(cmp_valid), .cmp_dst(cmp_dst), .sq_mask(sq_mask),
    .entry_ready(entry_ready), .preg_ready(preg_ready), .dup_err(dup_err)
  );

  // monitor: compares the oldest expectation against the outputs
  always @(negedge clk) begin
    if (q_req.size() > 0) begin
      string r; logic [NE-1:0] er; logic [NP-1:0] pr; logic de;
      r = q_req.pop_front(); er = q_er.pop_front();
      pr = q_pr.pop_front(); de = q_de.pop_front();
      n_chk++;
      if (entry_ready !== er || preg_ready !== pr || dup_err !== de) begin
        n_fail++;
        $display("FAIL %s: entry_ready=%b preg_ready=%b dup_err=%b, expected %b %b %b",
                 r, entry_ready, preg_ready, dup_err, er, pr, de);
      end
    end
  end

  task automatic idle_inputs();
    ins_valid = 0; ins_entry = 0; ins_src_vld = 0; ins_src_rdy = 0;
    ins_src0 = 0; ins_src1 = 0; ins_dst_vld = 0; ins_dst = 0;
    cmp_valid = 0; cmp_dst = 0; sq_mask = 0;
  endtask

  // driver: applies the prepared inputs for one edge and queues the expectation
  task automatic cyc(input string req, input logic [NE-1:0] er,
                     input logic [NP-1:0] pr, input logic de);
    @(posedge clk); #1;
    q_req.push_back(req); q_er.push_back(er); q_pr.push_back(pr); q_de.push_back(de);
    idle_inputs();
  endtask

  task automatic ins(input int e, input logic [1:0] sv, input logic [1:0] sr,
                     input int s0, input int s1, input logic dv, input int d);
    ins_valid = 1; ins_entry = 2'(e); ins_src_vld = sv; ins_src_rdy = sr;
    ins_src0 = IW'(s0); ins_src1 = IW'(s1); ins_dst_vld = dv; ins_dst = IW'(d);
  endtask

  task automatic cmp(input int d);
    cmp_valid = 1; cmp_dst = IW'(d);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    cyc("R1 reset state", 4'b0000, 8'h00, 0);
    cmp(1);                              cyc("R3 complete r1", 4'b0000, 8'h02, 0);
    cmp(2);                              cyc("R3 complete r2", 4'b0000, 8'h06, 0);
    cmp(9);                              cyc("R10 out-of-range completion", 4'b0000, 8'h06, 0);
    ins(0, 2'b01, 2'b00, 1, 0, 1, 2);    cyc("R5 ready source, R2 dst clear", 4'b0001, 8'h02, 0);
    ins(1, 2'b11, 2'b00, 3, 4, 1, 5);    cyc("R7 two pending sources", 4'b0001, 8'h02, 0);
    cmp(3);                              cyc("R7 one of two sources", 4'b0001, 8'h0A, 0);
    cmp(4);                              cyc("R7 R3 second source wakes", 4'b0011, 8'h1A, 0);
    ins(2, 2'b11, 2'b00, 6, 6, 1, 7);    cyc("R8 same register twice pending", 4'b0011, 8'h1A, 0);
    cmp(6);                              cyc("R8 one completion readies both", 4'b0111, 8'h5A, 0);
    ins(3, 2'b11, 2'b10, 0, 7, 1, 12); cmp(0);
                                         cyc("R6 R4 R10 in-flight bypass", 4'b1111, 8'h5B, 0);
    sq_mask = 4'b0011;                   cyc("R9 squash drops entries", 4'b1100, 8'h5B, 0);
    ins(0, 2'b11, 2'b00, 5, 10, 0, 0);   cyc("R10 oor source satisfied, R7 r5 pending", 4'b1100, 8'h5B, 0);
    ins(1, 2'b00, 2'b00, 0, 0, 1, 5);    cyc("R11 realloc with waiter", 4'b1110, 8'h5B, 1);
                                         cyc("R11 one-cycle pulse", 4'b1110, 8'h5B, 0);
    sq_mask = 4'b0001;                   cyc("R9 squash waiter", 4'b1110, 8'h5B, 0);
    ins(2, 2'b00, 2'b00, 0, 0, 1, 5);    cyc("R9 squashed waiter removed", 4'b1110, 8'h5B, 0);
    ins(0, 2'b00, 2'b00, 0, 0, 1, 5); cmp(5);
                                         cyc("R2 insert clear beats completion", 4'b1111, 8'h5B, 0);
    cmp(5);                              cyc("R3 complete r5", 4'b1111, 8'h7B, 0);
    ins(0, 2'b01, 2'b00, 2, 0, 0, 0);    cyc("R7 waiter A on r2", 4'b1110, 8'h7B, 0);
    ins(1, 2'b10, 2'b00, 0, 2, 0, 0);    cyc("R7 waiter B on r2", 4'b1100, 8'h7B, 0);
    cmp(2);                              cyc("R3 all waiters woken", 4'b1111, 8'h7F, 0);
    ins(3, 2'b01, 2'b00, 6, 0, 1, 3); cmp(6);
                                         cyc("R6 R2 bypass on ready reg", 4'b1111, 8'h77, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule